// File: doc/BRIEF.md
# Registered Inverting Bus Transceiver

This block connects two 8-bit bidirectional ports, A and B. Each transfer direction has its own capture register. The A-to-B register samples port A on the rising edge of its own clock. The B-to-A register samples port B on the rising edge of a second, separate clock. For each direction a select input chooses the source. One choice passes the live value from the opposite port straight through. The other replays the stored copy held in that direction's register. Whichever source is chosen, the value driven onto a port is the bitwise inverse of that source.

An active-low enable sets whether either port is driven at all. While the enable is active, a direction input picks the one port that is driven. When the enable is inactive the block is isolated and neither port is driven. Both registers keep capturing in every mode, so a value can be stored while the ports are isolated and replayed later. Each bidirectional port is split into an input, an output and an output-enable for use inside a chip.

Top module: `rbx_xcvr_top`

## Requirements
- R1: While `rst_n` is low, both registers are cleared to zero and both `a_oe` and `b_oe` are 0, whatever the other inputs are.
- R2: A rising edge of `clk_ab` stores `a_in` in the A-to-B register. A rising edge of `clk_ba` stores `b_in` in the B-to-A register. Each register holds its value otherwise.
- R3: When `sel_ab` is 0, `b_out` equals `~a_in` (live path). When `sel_ab` is 1, `b_out` equals the inverse of the A-to-B register.
- R4: When `sel_ba` is 0, `a_out` equals `~b_in`. When `sel_ba` is 1, `a_out` equals the inverse of the B-to-A register.
- R5: When `oe_n` is 1, `a_oe` and `b_oe` are both 0 (isolation).
- R6: When `oe_n` is 0, `dir`=1 gives `b_oe`=1 and `a_oe`=0, and `dir`=0 gives `a_oe`=1 and `b_oe`=0.
- R7: `a_oe` and `b_oe` are never 1 at the same time.
- R8: Register capture does not depend on `oe_n`, `dir` or the select inputs. Values captured while isolated are replayed later through the stored path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_ab | input | 1 | Capture clock for the A-to-B register |
| clk_ba | input | 1 | Capture clock for the B-to-A register |
| sel_ab | input | 1 | B source: 0 live A, 1 stored |
| sel_ba | input | 1 | A source: 0 live B, 1 stored |
| oe_n | input | 1 | Active-low output enable |
| dir | input | 1 | 1 drives B, 0 drives A |
| a_in | input | 8 | Value seen on port A |
| a_out | output | 8 | Value to drive on port A |
| a_oe | output | 1 | Drive enable for port A |
| b_in | input | 8 | Value seen on port B |
| b_out | output | 8 | Value to drive on port B |
| b_oe | output | 1 | Drive enable for port B |

## Verification
The bench goes after captures made while isolated. A design that gates capture with the enable would replay a stale register when the stored path is later selected. It also checks that the stored path is inverted exactly once. A design that inverts before storing as well as after would return the true value instead of the inverse. It then sweeps all sixteen combinations of enable, direction and both selects. A swapped select or a crossed direction would drive the wrong port or the wrong source. Finally, it asserts reset while the stored path is selected. A register with no reset or only a synchronous reset would keep old data visible.

// File: rtl/rbx_pkg.sv
package rbx_pkg;
   typedef enum logic {SRC_LIVE = 1'b0, SRC_STORED = 1'b1} rbx_src_e;
   typedef enum logic {DIR_TO_A = 1'b0, DIR_TO_B = 1'b1} rbx_dir_e;
endpackage

// File: rtl/rbx_store.sv
module rbx_store #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   initial assert (W > 0) else $error("rbx_store: W must be positive");
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
   end
endmodule

// File: rtl/rbx_path.sv
module rbx_path #(
   parameter int W = 8,
   parameter bit INVERT = 1'b1
) (
   input  logic         sel,
   input  logic [W-1:0] live,
   input  logic [W-1:0] stored,
   output logic [W-1:0] drv
);
   import rbx_pkg::*;
   logic [W-1:0] pick;
   always_comb pick = (rbx_src_e'(sel) == SRC_STORED) ? stored : live;
   generate
      if (INVERT) begin : g_inv
         assign drv = ~pick;
      end else begin : g_true
         assign drv = pick;
      end
   endgenerate
endmodule

// File: rtl/rbx_ctrl.sv
module rbx_ctrl (
   input  logic rst_n,
   input  logic oe_n,
   input  logic dir,
   output logic a_oe,
   output logic b_oe
);
   import rbx_pkg::*;
   logic en;
   always_comb begin
      en   = rst_n && !oe_n;
      b_oe = en && (rbx_dir_e'(dir) == DIR_TO_B);
      a_oe = en && (rbx_dir_e'(dir) == DIR_TO_A);
   end
endmodule

// File: rtl/rbx_xcvr_top.sv
module rbx_xcvr_top #(
   parameter int W = 8,
   parameter bit INVERT = 1'b1
) (
   input  logic         rst_n,
   input  logic         clk_ab,
   input  logic         clk_ba,
   input  logic         sel_ab,
   input  logic         sel_ba,
   input  logic         oe_n,
   input  logic         dir,
   input  logic [W-1:0] a_in,
   output logic [W-1:0] a_out,
   output logic         a_oe,
   input  logic [W-1:0] b_in,
   output logic [W-1:0] b_out,
   output logic         b_oe
);
   initial assert (W >= 1) else $error("rbx_xcvr_top: W must be at least 1");

   logic [W-1:0] reg_ab, reg_ba;

   rbx_store #(.W(W)) u_st_ab (.clk(clk_ab), .rst_n(rst_n), .d(a_in), .q(reg_ab));
   rbx_store #(.W(W)) u_st_ba (.clk(clk_ba), .rst_n(rst_n), .d(b_in), .q(reg_ba));

   rbx_path #(.W(W), .INVERT(INVERT)) u_p_ab (.sel(sel_ab), .live(a_in), .stored(reg_ab), .drv(b_out));
   rbx_path #(.W(W), .INVERT(INVERT)) u_p_ba (.sel(sel_ba), .live(b_in), .stored(reg_ba), .drv(a_out));

   rbx_ctrl u_ctrl (.rst_n(rst_n), .oe_n(oe_n), .dir(dir), .a_oe(a_oe), .b_oe(b_oe));
endmodule

// File: rtl/rbx_xcvr_chk.sv
module rbx_xcvr_chk #(
   parameter int W = 8
) (
   input logic         rst_n,
   input logic         clk_ab,
   input logic         clk_ba,
   input logic         oe_n,
   input logic         dir,
   input logic [W-1:0] a_in,
   input logic [W-1:0] b_in,
   input logic         a_oe,
   input logic         b_oe,
   input logic         sel_ab,
   input logic         sel_ba,
   input logic [W-1:0] a_out,
   input logic [W-1:0] b_out
);
   // R7
   always_comb begin
      one_drv_chk: assert (!(a_oe && b_oe)) else $error("both ports driven");
   end

   // R5
   always_comb begin
      if (oe_n) begin
         iso_chk: assert (!a_oe && !b_oe) else $error("drive while isolated");
      end
   end

   // R1
   always_comb begin
      if (!rst_n) begin
         rst_drv_chk: assert (!a_oe && !b_oe) else $error("drive in reset");
      end
   end

   // R3
   always_comb begin
      if (!sel_ab) begin
         live_ab_chk: assert (b_out == ~a_in) else $error("live A->B wrong");
      end
   end

   // R2
   stored_ab_chk: assert property (@(posedge clk_ab) disable iff (!rst_n)
      sel_ab |=> (!sel_ab || b_out == ~$past(a_in) || $past(a_in) !== $past(a_in)));

   // R4
   stored_ba_chk: assert property (@(posedge clk_ba) disable iff (!rst_n)
      sel_ba |=> (!sel_ba || a_out == ~$past(b_in)));
endmodule

bind rbx_xcvr_top rbx_xcvr_chk #(.W(W)) u_chk (
   .rst_n(rst_n), .clk_ab(clk_ab), .clk_ba(clk_ba), .oe_n(oe_n), .dir(dir),
   .a_in(a_in), .b_in(b_in), .a_oe(a_oe), .b_oe(b_oe),
   .sel_ab(sel_ab), .sel_ba(sel_ba), .a_out(a_out), .b_out(b_out));

// File: tb/rbx_xcvr_top_tb_top.sv
module rbx_xcvr_top_tb_top;
   localparam int W = 8;
   localparam time TCLK = 10ns;

   logic rst_n = 1'b0, clk_ab = 1'b0, clk_ba = 1'b0;
   logic sel_ab = 1'b0, sel_ba = 1'b0, oe_n = 1'b1, dir = 1'b0;
   logic [W-1:0] a_in = '0, b_in = '0;
   logic [W-1:0] a_out, b_out;
   logic a_oe, b_oe;
   logic [W-1:0] m_ab = '0, m_ba = '0;
   int n_chk = 0, n_bad = 0;
   bit done = 0;

   rbx_xcvr_top #(.W(W)) dut_i (
      .rst_n(rst_n), .clk_ab(clk_ab), .clk_ba(clk_ba), .sel_ab(sel_ab), .sel_ba(sel_ba),
      .oe_n(oe_n), .dir(dir), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
      .b_in(b_in), .b_out(b_out), .b_oe(b_oe));

   task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic pulse_ab();
      #(TCLK/2) clk_ab = 1; m_ab = rst_n ? a_in : '0; #(TCLK/2) clk_ab = 0; #1;
   endtask
   task automatic pulse_ba();
      #(TCLK/2) clk_ba = 1; m_ba = rst_n ? b_in : '0; #(TCLK/2) clk_ba = 0; #1;
   endtask

   task automatic check_all(string tag);
      logic eb, ea;
      #1;
      eb = rst_n && !oe_n && dir;
      ea = rst_n && !oe_n && !dir;
      chk({tag, " R5 R6 R7 b_oe"}, W'(b_oe), W'(eb));
      chk({tag, " R5 R6 R7 a_oe"}, W'(a_oe), W'(ea));
      chk({tag, " R3 b_out"}, b_out, sel_ab ? ~m_ab : ~a_in);
      chk({tag, " R4 a_out"}, a_out, sel_ba ? ~m_ba : ~b_in);
   endtask

   task automatic t_reset();
      oe_n = 0; dir = 1; sel_ab = 1; sel_ba = 1; #2;
      chk("R1 rst b_oe", W'(b_oe), '0);
      chk("R1 rst a_oe", W'(a_oe), '0);
      chk("R1 rst reg_ab", b_out, 8'hFF);
      chk("R1 rst reg_ba", a_out, 8'hFF);
      rst_n = 1; #2;
   endtask

   task automatic t_capture_isolated();
      oe_n = 1; sel_ab = 0; sel_ba = 0;
      a_in = 8'h3C; b_in = 8'hA5; pulse_ab(); pulse_ba();
      a_in = 8'h00; b_in = 8'hFF; #1;
      check_all("iso");
      sel_ab = 1; sel_ba = 1; oe_n = 0; dir = 1; #1;
      chk("R8 R2 stored ab", b_out, 8'hC3);
      dir = 0; #1;
      chk("R8 R2 stored ba", a_out, 8'h5A);
      chk("R2 hold", W'(a_oe), 1);
   endtask

   task automatic t_sweep();
      for (int k = 0; k < 16; k++) begin
         {oe_n, dir, sel_ab, sel_ba} = 4'(k);
         a_in = 8'(k * 37 + 1); b_in = 8'(k * 91 + 7);
         check_all("sweep");
         if (k % 3 == 0) pulse_ab();
         if (k % 4 == 1) pulse_ba();
         check_all("sweep post");
      end
   endtask

   task automatic t_capture_live();
      oe_n = 0; dir = 1; sel_ab = 0;
      a_in = 8'h81; pulse_ab(); a_in = 8'h7E; #1;
      chk("R3 live", b_out, 8'h81);
      sel_ab = 1; #1;
      chk("R2 R3 stored once-inverted", b_out, 8'h7E);
   endtask

   task automatic t_reset_again();
      rst_n = 0; m_ab = '0; m_ba = '0; sel_ab = 1; sel_ba = 1; #2;
      chk("R1 async clear b", b_out, 8'hFF);
      chk("R1 async clear a", a_out, 8'hFF);
      a_in = 8'h55; pulse_ab();
      chk("R1 held in reset", b_out, 8'hFF);
      rst_n = 1; #2;
      check_all("post-reset");
   endtask

   initial begin
      #(TCLK * 20000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #3;
      t_reset();
      t_capture_isolated();
      t_sweep();
      t_capture_live();
      t_reset_again();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule